// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received frames into host memory. Frames arrive as a byte stream that has a last-byte marker. On the last byte the stream also carries three error flags: framing, CRC mismatch and FIFO fault. The CRC is checked upstream, and its verdict is one of those flags. For each frame the block reads the current descriptor from a word-wide memory port. It writes the frame bytes into the buffer that the descriptor names. It then writes back the byte count and a status word that returns the descriptor to the host.

A descriptor is four 32-bit words at a 16-byte stride from the ring base:

| Offset | Contents |
|---|---|
| +0 | Buffer byte address (word aligned) |
| +4 | Bits 15:0: buffer length, stored negated (two's complement). Bits 31:16: status |
| +8 | Bits 11:0: message length |
| +12 | Reserved, never accessed |

The host programs the ring base and a 16-bit ring-length word with a one-cycle load pulse. The ring holds 2^n descriptors, where n is read from bits 7:4 of that word.

The memory port accepts one request per cycle. Read data appears on `mem_rdata` in the cycle after a read request.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset and until the first configuration load, `rx_ready` and `mem_req` stay low and `missed_count` is 0. A pending byte is not consumed.
- R2: At the start of each frame the block reads the word at descriptor offset +4. If its bit 31 (the host-hands-over flag) is 0, the whole frame is consumed with no memory write, the ring index stays put, and `missed_count` goes up by exactly one.
- R3: Frame bytes are written little-endian from the buffer address upward: byte k goes to byte lane k mod 4 of word k/4. A trailing partial word is written with only its filled lanes enabled, so the bytes after the frame in memory are left unchanged.
- R4: A clean frame of L bytes, with L not above the buffer size, writes L to bits 11:0 of offset +8 (L counts every byte of the stream, including its CRC bytes). It writes offset +4 with bits 31:24 equal to 0x03, bits 23:16 equal to 0, and bits 15:0 kept as read. Bit 31 therefore returns to 0.
- R5: Error flags set bits in status byte 31:24: framing 0x20, CRC 0x08, FIFO 0x04. Any error also sets 0x40. A frame that fits keeps 0x03, so a framing error alone gives 0x63.
- R6: The buffer size is the negation of bits 15:0 of offset +4. Bytes beyond that size are not written. The length word then reports the buffer size, and the status byte holds 0x52 (error 0x40, overflow 0x10, first-buffer 0x02) with the end-of-frame bit 0x01 cleared.
- R7: The write to offset +8 is issued in the cycle before the status write to offset +4, and both come after the last buffer write.
- R8: After the descriptor at index 2^n−1 is handed back, the next frame uses index 0.
- R9: A configuration load sets the ring index back to 0 and takes the new base and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | One-cycle pulse that takes the ring base and length word |
| cfg_ring_base | input | AW | Byte address of descriptor 0 |
| cfg_ring_len | input | 16 | Ring-length word; bits 7:4 hold log2 of the entry count |
| rx_valid | input | 1 | Stream byte present |
| rx_ready | output | 1 | Block takes the byte this cycle |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_err_frame | input | 1 | Framing error, valid with rx_last |
| rx_err_crc | input | 1 | CRC mismatch, valid with rx_last |
| rx_err_fifo | input | 1 | FIFO fault, valid with rx_last |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| missed_count | output | MISS_W | Frames dropped because the descriptor was still held by the host |

## Verification
Directed frames cover the following cases:
- One byte, which exercises the single-lane enable.
- Five bytes, where the tail word leaves three lanes untouched.
- Exactly the buffer size, which fits with no overflow.
- Six bytes past the buffer size, which must stop at the buffer end and set status 0x52.

Each error flag is sent on its own, so every cause bit is checked separately from the others.

Random lengths on both sides of the buffer size, with random flag mixes, test the length and status encoding together.

Other frames target the ring itself:
- A frame sent to a descriptor still held by the host tells "dropped and counted" apart from "written anyway".
- A reload to a two-entry ring checks that wrapping follows the new size and not the old one.

// File: rtl/rxd_pkg.sv
// Shared states and status encoding for the receive descriptor ring writer.
// Assumes descriptors are four 32-bit words and the status byte is word1[31:24].
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_BASE,
        ST_FILL,
        ST_DROP,
        ST_WR_LEN,
        ST_WR_STAT
    } rxd_state_e;

    localparam int OWN_BIT   = 31;
    localparam int LEN_BITS  = 12;
    localparam int LANES     = 4;

    // Build the high status byte: {0, err, frame, oflo, crc, fifo, stp, enp}.
    function automatic logic [7:0] status_hi(input logic fr, input logic ov,
                                             input logic crc, input logic fifo);
        return {1'b0, (fr | ov | crc | fifo), fr, ov, crc, fifo, 1'b1, ~ov};
    endfunction

endpackage

// File: rtl/rxd_ring_index.sv
// Holds ring base, ring size exponent and the current descriptor index.
// Assumes the size exponent never exceeds MAX_LOG2; larger codes are clamped.
module rxd_ring_index #(
    parameter int AW       = 32,
    parameter int MAX_LOG2 = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic [3:0]    size_log2,
    input  logic          advance,
    output logic          configured,
    output logic [AW-1:0] desc_addr
);
    localparam int IDX_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [AW-1:0]  base_q;
    logic [3:0]     log2_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W:0] ring_size;
    logic [IDX_W:0] last_idx;

    // Entry count and last valid index of the ring.
    always_comb begin
        ring_size = (IDX_W+1)'(1) << log2_q;
        last_idx  = ring_size - (IDX_W+1)'(1);
    end

    // Byte address of the current descriptor (16-byte stride).
    assign desc_addr = base_q + (AW'(idx_q) << 4);

    // Configuration capture and index advance with wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            configured <= 1'b0;
            base_q     <= '0;
            log2_q     <= '0;
            idx_q      <= '0;
        end else if (load) begin
            configured <= 1'b1;
            base_q     <= base_in;
            log2_q     <= (size_log2 > 4'(MAX_LOG2)) ? 4'(MAX_LOG2) : size_log2;
            idx_q      <= '0;
        end else if (advance) begin
            idx_q <= ({1'b0, idx_q} == last_idx) ? '0 : idx_q + 1'b1;
        end
    end

    a_r8_index_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        configured |-> ({1'b0, idx_q} < ring_size));

    a_r9_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (idx_q == '0));

endmodule

// File: rtl/rxd_byte_packer.sv
// Gathers stream bytes into little-endian words and emits a word when it is
// full or the frame ends. Assumes the caller writes emitted words in order.
module rxd_byte_packer #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic               finish,
    input  logic [7:0]         din,
    output logic               emit,
    output logic [8*LANES-1:0] word,
    output logic [LANES-1:0]   be
);
    localparam int LW = $clog2(LANES);

    logic [LW-1:0]      lane_q;
    logic [8*LANES-1:0] hold_q;

    // Per-lane merge of the incoming byte and lane enables.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word[g*8 +: 8] = (push && lane_q == LW'(g)) ? din : hold_q[g*8 +: 8];
        assign be[g]          = (LW'(g) < lane_q) || (push && lane_q == LW'(g));
    end

    // Emit on a full word, or on frame end with anything gathered.
    assign emit = push ? ((lane_q == LW'(LANES-1)) || finish)
                       : (finish && (lane_q != '0));

    // Lane pointer and partial-word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            hold_q <= '0;
        end else if (clear || emit) begin
            lane_q <= '0;
            hold_q <= '0;
        end else if (push) begin
            lane_q <= lane_q + 1'b1;
            hold_q <= word;
        end
    end

    a_r3_lane0_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> be[0]);

    a_r3_lanes_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (((be + LANES'(1)) & be) == '0));

endmodule

// File: rtl/rxd_ring_writer.sv
// Receive descriptor ring writer: fetches the current descriptor, fills its
// buffer from the byte stream, then writes length and status back.
// Assumes one-cycle read latency on the memory port and word-aligned buffers.
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_LOG2 = 15,
    parameter int MISS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [AW-1:0]     cfg_ring_base,
    input  logic [15:0]       cfg_ring_len,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err_frame,
    input  logic              rx_err_crc,
    input  logic              rx_err_fifo,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [MISS_W-1:0] missed_count
);
    localparam int CNT_W = 16;

    rxd_state_e       state_q, state_d;
    logic [15:0]      neglen_q;
    logic [AW-1:0]    bufbase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ov_q, fr_q, crc_q, fifo_q;
    logic [MISS_W-1:0] miss_q;

    logic             configured;
    logic [AW-1:0]    desc_addr;
    logic [CNT_W-1:0] bsize;
    logic             room, accept, push, finish;
    logic             pk_emit;
    logic [31:0]      pk_word;
    logic [3:0]       pk_be;
    logic [CNT_W-1:0] word_off;
    logic             unused_bits;

    assign unused_bits = ^{cfg_ring_len[15:8], cfg_ring_len[3:0], mem_rdata[30:16]};

    rxd_ring_index #(.AW(AW), .MAX_LOG2(MAX_LOG2)) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .base_in    (cfg_ring_base),
        .size_log2  (cfg_ring_len[7:4]),
        .advance    (state_q == ST_WR_STAT),
        .configured (configured),
        .desc_addr  (desc_addr)
    );

    // Stream acceptance and byte routing into the packer.
    always_comb begin
        bsize    = ~neglen_q + 16'd1;
        room     = cnt_q < bsize;
        rx_ready = (state_q == ST_FILL) || (state_q == ST_DROP);
        accept   = rx_valid && rx_ready;
        push     = (state_q == ST_FILL) && accept && room;
        finish   = (state_q == ST_FILL) && accept && rx_last;
        word_off = {cnt_q[CNT_W-1:2], 2'b00};
    end

    rxd_byte_packer #(.LANES(LANES)) u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == ST_RD_BASE),
        .push   (push),
        .finish (finish),
        .din    (rx_data),
        .emit   (pk_emit),
        .word   (pk_word),
        .be     (pk_be)
    );

    // Next-state selection for the per-frame sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (configured && rx_valid) state_d = ST_RD_STAT;
            ST_RD_STAT: state_d = mem_rdata[OWN_BIT] ? ST_RD_BASE : ST_DROP;
            ST_RD_BASE: state_d = ST_FILL;
            ST_FILL:    if (accept && rx_last) state_d = ST_WR_LEN;
            ST_DROP:    if (accept && rx_last) state_d = ST_IDLE;
            ST_WR_LEN:  state_d = ST_WR_STAT;
            ST_WR_STAT: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Memory request generation per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr + AW'(4);
        mem_be    = 4'hF;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE:    mem_req = configured && rx_valid;
            ST_RD_STAT: begin
                mem_req  = mem_rdata[OWN_BIT];
                mem_addr = desc_addr;
            end
            ST_FILL: begin
                mem_req   = pk_emit;
                mem_we    = 1'b1;
                mem_addr  = bufbase_q + AW'(word_off);
                mem_be    = pk_be;
                mem_wdata = pk_word;
            end
            ST_WR_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + AW'(8);
                mem_wdata = {{(32-LEN_BITS){1'b0}}, cnt_q[LEN_BITS-1:0]};
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {status_hi(fr_q, ov_q, crc_q, fifo_q), 8'h00, neglen_q};
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor fields, byte count, error flags and missed-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neglen_q  <= '0;
            bufbase_q <= '0;
            cnt_q     <= '0;
            ov_q      <= 1'b0;
            fr_q      <= 1'b0;
            crc_q     <= 1'b0;
            fifo_q    <= 1'b0;
            miss_q    <= '0;
        end else begin
            case (state_q)
                ST_RD_STAT: begin
                    neglen_q <= mem_rdata[15:0];
                    if (!mem_rdata[OWN_BIT]) miss_q <= miss_q + 1'b1;
                end
                ST_RD_BASE: begin
                    bufbase_q <= AW'(mem_rdata);
                    cnt_q     <= '0;
                    ov_q      <= 1'b0;
                    fr_q      <= 1'b0;
                    crc_q     <= 1'b0;
                    fifo_q    <= 1'b0;
                end
                ST_FILL: if (accept) begin
                    if (room) cnt_q <= cnt_q + 1'b1;
                    else      ov_q  <= 1'b1;
                    if (rx_last) begin
                        fr_q   <= rx_err_frame;
                        crc_q  <= rx_err_crc;
                        fifo_q <= rx_err_fifo;
                    end
                end
                default: ;
            endcase
        end
    end

    assign missed_count = miss_q;

    a_r1_quiet_until_config: assert property (@(posedge clk) disable iff (!rst_n)
        !configured |-> (!rx_ready && !mem_req));

    a_r2_drop_writes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !mem_req);

    a_r2_miss_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_count == $past(missed_count)) ||
        (missed_count == $past(missed_count) + 1'b1));

    a_r6_write_inside_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_req) |-> (word_off < bsize));

    a_r7_status_after_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_STAT) |-> ($past(state_q) == ST_WR_LEN));

endmodule

// File: tb/rxd_ring_writer_bench.sv
`timescale 1ns/1ps
module rxd_ring_writer_bench;

    localparam int BUF_BYTES = 64;
    localparam logic [15:0] NEG_LEN = 16'hFFC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_ring_base = '0;
    logic [15:0] cfg_ring_len = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err_frame = 1'b0;
    logic        rx_err_crc = 1'b0;
    logic        rx_err_fifo = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;
    logic [15:0] missed_count;

    logic [31:0] mem [0:1023];
    logic [7:0]  fb [0:127];
    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    int ring_sz = 4;
    int exp_miss = 0;

    always #4 clk = ~clk;

    rxd_ring_writer u_rxd_ring_writer (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ring_base(cfg_ring_base),
        .cfg_ring_len(cfg_ring_len), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_err_frame(rx_err_frame),
        .rx_err_crc(rx_err_crc), .rx_err_fifo(rx_err_fifo), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .missed_count(missed_count)
    );

    // Host memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hi(input int len, input bit f,
                                          input bit c, input bit o);
        bit ov = (len > BUF_BYTES);
        logic [7:0] v = 8'h02;
        if (!ov) v |= 8'h01;
        if (ov)  v |= 8'h10;
        if (f)   v |= 8'h20;
        if (c)   v |= 8'h08;
        if (o)   v |= 8'h04;
        if (ov || f || c || o) v |= 8'h40;
        return v;
    endfunction

    function automatic int buf_addr(input int slot);
        return 32'h100 + slot * 32'h80;
    endfunction

    task automatic arm(input int slot, input bit own);
        mem[slot*4 + 0] = buf_addr(slot);
        mem[slot*4 + 1] = {own, 15'h0, NEG_LEN};
        mem[slot*4 + 2] = 32'h0;
        mem[slot*4 + 3] = 32'h0;
        for (int w = 0; w < 32; w++) mem[buf_addr(slot)/4 + w] = 32'hEEEE_EEEE;
    endtask

    task automatic send(input int len, input bit f, input bit c, input bit o);
        for (int i = 0; i < len; i++) begin
            rx_valid     = 1'b1;
            rx_data      = fb[i];
            rx_last      = (i == len - 1);
            rx_err_frame = (i == len - 1) && f;
            rx_err_crc   = (i == len - 1) && c;
            rx_err_fifo  = (i == len - 1) && o;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
        rx_err_frame = 1'b0; rx_err_crc = 1'b0; rx_err_fifo = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(input int len, input bit f, input bit c, input bit o);
        int slot = exp_idx;
        int stored = (len > BUF_BYTES) ? BUF_BYTES : len;
        int bad = 0;
        logic [7:0] got;
        string tag = (len > BUF_BYTES) ? "R6" : ((f || c || o) ? "R5" : "R4");
        arm(slot, 1'b1);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        send(len, f, c, o);
        for (int i = 0; i < stored; i++) begin
            got = mem[buf_addr(slot)/4 + i/4][8*(i%4) +: 8];
            if (got !== fb[i]) bad++;
        end
        check("R3", "buffer byte mismatches", bad, 0);
        if (stored % 4 != 0) begin
            got = mem[buf_addr(slot)/4 + stored/4][31:24];
            check("R3", "tail lane untouched", {24'h0, got}, 32'hEE);
        end
        check("R6", "word after buffer untouched", mem[buf_addr(slot)/4 + 16], 32'hEEEE_EEEE);
        check(tag, "length word", mem[slot*4 + 2], stored);
        check(tag, "status word", mem[slot*4 + 1],
              {exp_hi(len, f, c, o), 8'h00, NEG_LEN});
        check("R8", "missed count steady", {16'h0, missed_count}, exp_miss);
        exp_idx = (exp_idx + 1) % ring_sz;
    endtask

    task automatic load_cfg(input logic [15:0] lenw);
        @(negedge clk);
        cfg_load = 1'b1; cfg_ring_base = 32'h0; cfg_ring_len = lenw;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd9157));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rx_ready after reset", {31'h0, rx_ready}, 0);
        check("R1", "mem_req after reset", {31'h0, mem_req}, 0);
        check("R1", "missed after reset", {16'h0, missed_count}, 0);
        rx_valid = 1'b1; rx_data = 8'h5A;
        repeat (6) @(negedge clk);
        check("R1", "rx_ready before config", {31'h0, rx_ready}, 0);
        check("R1", "mem_req before config", {31'h0, mem_req}, 0);
        rx_valid = 1'b0;

        load_cfg(16'h0020);
        ring_sz = 4; exp_idx = 0;
        frame(1, 0, 0, 0);
        frame(5, 0, 0, 0);
        frame(64, 0, 0, 0);
        frame(70, 0, 0, 0);
        frame(20, 1, 0, 0);   // R8: wrapped to index 0
        frame(33, 0, 1, 0);
        frame(47, 0, 0, 1);
        frame(66, 1, 1, 0);

        for (int k = 0; k < 14; k++)
            frame(int'($urandom_range(1, 72)), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));

        // R2: descriptor still held by the host.
        arm(exp_idx, 1'b0);
        for (int i = 0; i < 10; i++) fb[i] = 8'($urandom);
        send(10, 0, 0, 0);
        exp_miss++;
        check("R2", "missed count", {16'h0, missed_count}, exp_miss);
        check("R2", "held status untouched", mem[exp_idx*4 + 1], {16'h0, NEG_LEN});
        check("R2", "held buffer untouched", mem[buf_addr(exp_idx)/4], 32'hEEEE_EEEE);
        frame(12, 0, 0, 0);   // R2: same index reused

        // R9: reload to a two-entry ring restarts at index 0.
        load_cfg(16'h0010);
        ring_sz = 2; exp_idx = 0;
        arm(2, 1'b1);
        frame(9, 0, 0, 0);
        frame(17, 0, 0, 0);
        frame(8, 0, 0, 0);    // R8: wraps at the new size
        check("R9", "slot 2 unused after reload", mem[2*4 + 2], 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule